// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This bridge sits on the host side of a 32-bit multiplexed address/data bus. It gives a processor two 32-bit registers on a small request/acknowledge port. One register holds the configuration target. The other is a data window. A read or write of the data window becomes one configuration cycle on the bus. The target is chosen geographically: the bridge raises the single upper address line that belongs to the device number. It does not drive an address that targets must decode.

The address register holds an enable bit, an 8-bit bus number, a 5-bit device number, a 3-bit function number and a 6-bit doubleword register number. A cycle starts with an address phase, which is held for a few clocks so that the slow select line can settle. A wait phase follows, in which the bridge looks for the target's claim. If no target claims within a bounded number of clocks, the bridge ends the cycle with a master abort and returns all ones. This lets enumeration software tell that a function is absent. Accesses that the bridge cannot place on the local bus end at once in the same way: the window is disabled, the bus number is non-zero, or the device has no select line.

Top module: `cfg_bridge`

## Requirements
- R1: The address register keeps bit 31 (enable), bits 23:16 (bus), 15:11 (device), 10:8 (function) and 7:2 (register). Bits 30:24 and 1:0 read back as zero. An address-register access is acknowledged one clock after the request.
- R2: A data-window access while the enable bit is clear starts no cycle. It is acknowledged one clock later with the abort flag set and read data 0xFFFFFFFF.
- R3: In the address phase, AD[1:0] are zero, AD[7:2] carry the register number and AD[10:8] carry the function number. AD[11+device] is the only upper bit set; AD[31:11] has exactly one bit high.
- R4: The address phase lasts SEL_HOLD clocks (default 2), with the address word stable and driven. A claim during the address phase is not taken, so the earliest acknowledge comes SEL_HOLD+1 clocks after the request.
- R5: A claim sampled in the wait phase ends the cycle. The acknowledge comes on the next clock with the target's read data, the abort flag clear, and the cycle line low.
- R6: If no claim arrives within CLAIM_WAIT wait clocks (default 5), the bridge ends the cycle with a master abort. It acknowledges with the abort flag set and read data 0xFFFFFFFF, so a cycle lasts at most SEL_HOLD+CLAIM_WAIT clocks.
- R7: A data-window access to a device number above 20, or to a non-zero bus number, starts no cycle. It is acknowledged one clock later as an abort with read data 0xFFFFFFFF.
- R8: In a write cycle the write strobe is high for the whole cycle. The write data is driven on AD during the wait phase. A successful write returns read data zero.
- R9: Requests made while a cycle is in progress are ignored, including writes to the address register.
- R10: After reset, no cycle is active, the acknowledge is low and the address register is zero. Every acknowledge is a single-clock pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | One-clock request strobe |
| cpu_sel | input | 1 | 0 selects the address register, 1 the data window |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | One-clock completion pulse |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack |
| cpu_abort | output | 1 | Set with cpu_ack when the access ended in an abort |
| cfg_cyc | output | 1 | High while a configuration cycle is in progress |
| cfg_we | output | 1 | High during a write cycle |
| cfg_ad_oe | output | 1 | Bridge drives cfg_ad |
| cfg_ad | output | 32 | Multiplexed address/data output |
| tgt_claim | input | 1 | Target claims the current cycle |
| tgt_rdata | input | 32 | Target read data, taken with the claim |

## Verification
Reads are claimed at the first and the last allowed wait clock. These show that the claim window has the right bounds, and that the returned word comes from the target and not from a constant. Device 0 and device 20 use different function and register values. This separates a correct one-hot select and field placement from a shifted or truncated encoding. Targets that never claim, a disabled window, device 21 and a non-zero bus each give all ones. Only the timeout path produces bus activity, so the four cases separate the timeout from the immediate aborts. A claim held from the moment of the request, and a request injected mid-cycle, expose a bridge that samples the target too early or that accepts a new request while busy.

// File: rtl/cfg_bridge.sv
`timescale 1ns/1ps
module cfg_bridge #(
  parameter int SEL_HOLD   = 2,
  parameter int CLAIM_WAIT = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_sel,
  input  logic        cpu_we,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_ack,
  output logic [31:0] cpu_rdata,
  output logic        cpu_abort,
  output logic        cfg_cyc,
  output logic        cfg_we,
  output logic        cfg_ad_oe,
  output logic [31:0] cfg_ad,
  input  logic        tgt_claim,
  input  logic [31:0] tgt_rdata
);
  localparam int SEL_BASE  = 11;
  localparam int DEV_LIMIT = 31 - SEL_BASE;
  localparam int CNT_MAX   = (SEL_HOLD > CLAIM_WAIT) ? SEL_HOLD : CLAIM_WAIT;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam logic [31:0] ADDR_MASK = 32'h80FF_FFFC;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_WAIT} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      addr_q, wd_q, rd_q;
  logic             we_q, ack_q, ab_q;

  wire       en_f  = addr_q[31];
  wire [7:0] bus_f = addr_q[23:16];
  wire [4:0] dev_f = addr_q[15:11];
  wire       no_path = !en_f || (bus_f != 8'd0) || (int'(dev_f) > DEV_LIMIT);

  wire [31:0] sel_line  = 32'd1 << (6'(SEL_BASE) + 6'(dev_f));
  wire [31:0] addr_word = sel_line | {21'd0, addr_q[10:2], 2'b00};

  assign cfg_cyc   = (st != S_IDLE);
  assign cfg_we    = cfg_cyc && we_q;
  assign cfg_ad_oe = (st == S_ADDR) || (st == S_WAIT && we_q);
  assign cfg_ad    = (st == S_ADDR) ? addr_word :
                     (st == S_WAIT && we_q) ? wd_q : 32'd0;
  assign cpu_ack   = ack_q;
  assign cpu_rdata = rd_q;
  assign cpu_abort = ab_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      we_q   <= 1'b0;
      ack_q  <= 1'b0;
      ab_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      ab_q  <= 1'b0;
      case (st)
        S_IDLE: if (cpu_req) begin
          if (!cpu_sel) begin
            ack_q <= 1'b1;
            if (cpu_we) begin
              addr_q <= cpu_wdata & ADDR_MASK;
              rd_q   <= '0;
            end else begin
              rd_q   <= addr_q;
            end
          end else if (no_path) begin
            ack_q <= 1'b1;
            ab_q  <= 1'b1;
            rd_q  <= '1;
          end else begin
            st   <= S_ADDR;
            cnt  <= '0;
            we_q <= cpu_we;
            wd_q <= cpu_wdata;
          end
        end
        S_ADDR: begin
          if (cnt == CNT_W'(SEL_HOLD - 1)) begin
            st  <= S_WAIT;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (tgt_claim) begin
            ack_q <= 1'b1;
            rd_q  <= we_q ? 32'd0 : tgt_rdata;
            st    <= S_IDLE;
          end else if (cnt == CNT_W'(CLAIM_WAIT - 1)) begin
            ack_q <= 1'b1;
            ab_q  <= 1'b1;
            rd_q  <= '1;
            st    <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_bridge_chk.sv
`timescale 1ns/1ps
module cfg_bridge_chk #(
  parameter int SEL_HOLD   = 2,
  parameter int CLAIM_WAIT = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_ack,
  input logic [31:0] cpu_rdata,
  input logic        cpu_abort,
  input logic        cfg_cyc,
  input logic        cfg_we,
  input logic        cfg_ad_oe,
  input logic [31:0] cfg_ad
);
  logic [7:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else        run <= cfg_cyc ? run + 8'd1 : 8'd0;
  end

  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

  p_abort_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_abort |-> (cpu_ack && cpu_rdata == 32'hFFFF_FFFF));

  p_addr_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_cyc) |-> (cfg_ad_oe && cfg_ad[1:0] == 2'b00 && $countones(cfg_ad[31:11]) == 1));

  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_cyc) |=> (cfg_cyc && cfg_ad_oe && $stable(cfg_ad)));

  p_cyc_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run) <= SEL_HOLD + CLAIM_WAIT);

  p_we_in_cyc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> cfg_cyc);

  p_no_ack_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cyc && $past(cfg_cyc)) |-> !cpu_ack);
endmodule

bind cfg_bridge cfg_bridge_chk #(.SEL_HOLD(SEL_HOLD), .CLAIM_WAIT(CLAIM_WAIT)) u_chk (.*);

// File: tb/cfg_bridge_bench.sv
`timescale 1ns/1ps
module cfg_bridge_bench;
  localparam int HOLD = 2;
  localparam int TMO  = 5;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_sel = 0, cpu_we = 0;
  logic [31:0] cpu_wdata = 0;
  logic cpu_ack, cpu_abort, cfg_cyc, cfg_we, cfg_ad_oe;
  logic [31:0] cpu_rdata, cfg_ad;
  logic tgt_claim = 0;
  logic [31:0] tgt_rdata = 0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_addr = 0;

  always #5 clk = ~clk;

  cfg_bridge #(.SEL_HOLD(HOLD), .CLAIM_WAIT(TMO)) u_cfg_bridge (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle_chk(input string tag);
    chk(tag, "cyc idle", {31'd0, cfg_cyc}, 32'd0);
    chk(tag, "ack idle", {31'd0, cpu_ack}, 32'd0);
    chk(tag, "oe idle", {31'd0, cfg_ad_oe}, 32'd0);
  endtask

  // claim_j: wait-phase index of the claim, -1 for none; early: claim held from the request
  task automatic access(input string tag, input logic sel, input logic we, input logic [31:0] wd,
                        input int claim_j, input logic [31:0] trd, input logic early, input logic poke);
    logic [4:0] dev; logic [7:0] bus; logic en; logic immed; logic claimed;
    logic [31:0] exp_addr, exp_rd;
    en = m_addr[31]; bus = m_addr[23:16]; dev = m_addr[15:11];
    exp_addr = (32'd1 << (11 + int'(dev))) | {21'd0, m_addr[10:8], m_addr[7:2], 2'b00};
    immed = !sel || !en || bus != 0 || dev > 20;
    @(negedge clk);
    cpu_req = 1; cpu_sel = sel; cpu_we = we; cpu_wdata = wd;
    if (early) begin tgt_claim = 1; tgt_rdata = trd; end
    @(negedge clk);
    cpu_req = 0;
    if (immed) begin
      if (!sel) exp_rd = we ? 32'd0 : m_addr;
      else      exp_rd = 32'hFFFF_FFFF;
      chk(tag, "immediate ack", {31'd0, cpu_ack}, 32'd1);
      chk(tag, "immediate rdata", cpu_rdata, exp_rd);
      chk(tag, "immediate abort", {31'd0, cpu_abort}, {31'd0, sel});
      chk(tag, "no cycle", {31'd0, cfg_cyc}, 32'd0);
      if (!sel && we) m_addr = wd & 32'h80FF_FFFC;
    end else begin
      for (int i = 0; i < HOLD; i++) begin
        chk(tag, "addr phase cyc", {31'd0, cfg_cyc}, 32'd1);
        chk(tag, "addr phase oe", {31'd0, cfg_ad_oe}, 32'd1);
        chk(tag, "addr phase word", cfg_ad, exp_addr);
        chk(tag, "addr phase we", {31'd0, cfg_we}, {31'd0, we});
        chk(tag, "no ack in addr", {31'd0, cpu_ack}, 32'd0);
        @(negedge clk);
      end
      claimed = 0;
      for (int j = 0; j < TMO; j++) begin
        chk(tag, "wait cyc", {31'd0, cfg_cyc}, 32'd1);
        chk(tag, "wait oe", {31'd0, cfg_ad_oe}, {31'd0, we});
        chk(tag, "wait ad", cfg_ad, we ? wd : 32'd0);
        chk(tag, "no ack in wait", {31'd0, cpu_ack}, 32'd0);
        if (j == claim_j) begin tgt_claim = 1; tgt_rdata = trd; claimed = 1; end
        if (poke && j == 0) begin cpu_req = 1; cpu_sel = 0; cpu_we = 1; cpu_wdata = 32'h8000_3800; end
        @(negedge clk);
        cpu_req = 0;
        if (claimed) break;
      end
      tgt_claim = 0;
      exp_rd = claimed ? (we ? 32'd0 : trd) : 32'hFFFF_FFFF;
      chk(tag, "end ack", {31'd0, cpu_ack}, 32'd1);
      chk(tag, "end rdata", cpu_rdata, exp_rd);
      chk(tag, "end abort", {31'd0, cpu_abort}, {31'd0, !claimed});
      chk(tag, "cycle over", {31'd0, cfg_cyc}, 32'd0);
    end
    @(negedge clk);
    idle_chk("R10");
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_chk("R10");
    rst_n = 1;
    @(negedge clk);
    idle_chk("R10");
    access("R1", 0, 0, 0, -1, 0, 0, 0);
    access("R1", 0, 1, 32'h0000_1800, -1, 0, 0, 0);
    access("R2", 1, 0, 0, -1, 0, 0, 0);
    access("R2", 1, 1, 32'h1111_2222, -1, 0, 0, 0);
    access("R1", 0, 1, 32'hFFFF_FFFF, -1, 0, 0, 0);
    access("R1", 0, 0, 0, -1, 0, 0, 0);
    access("R7", 1, 0, 0, -1, 0, 0, 0);
    access("R3", 0, 1, 32'h8000_0000, -1, 0, 0, 0);
    access("R5", 1, 0, 0, 0, 32'h1234_5678, 0, 0);
    access("R3", 0, 1, 32'h8000_A7FC, -1, 0, 0, 0);
    access("R5", 1, 0, 0, TMO - 1, 32'hCAFE_F00D, 0, 0);
    access("R7", 0, 1, 32'h8000_A800, -1, 0, 0, 0);
    access("R7", 1, 0, 0, -1, 0, 0, 0);
    access("R6", 0, 1, 32'h8000_2910, -1, 0, 0, 0);
    access("R6", 1, 0, 0, -1, 0, 0, 0);
    access("R8", 0, 1, 32'h8000_3A14, -1, 0, 0, 0);
    access("R8", 1, 1, 32'h0000_A5A5, 2, 32'h5555_5555, 0, 0);
    access("R8", 1, 1, 32'hDEAD_BEEF, -1, 0, 0, 0);
    access("R4", 0, 1, 32'h8000_0B08, -1, 0, 0, 0);
    access("R4", 1, 0, 0, 0, 32'h0BAD_CAFE, 1, 0);
    access("R9", 1, 0, 0, 3, 32'h7777_0001, 0, 1);
    access("R9", 0, 0, 0, -1, 0, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule